// File: doc/BRIEF.md
# Synchronous Receive Sync Hunter

This block is the front end of a character-oriented synchronous receiver. It takes a recovered serial bit stream, qualified by a one-cycle bit enable, and hunts for a programmable sync pattern of 2 to 16 bits. While hunting it keeps a sliding window of the most recent bits. When the last L bits received match the low L bits of the pattern value, where L is the programmed sync length, it declares sync. It then cuts the bit stream into characters of 1 to 8 bits. Each completed character is presented on a parallel output with a one-cycle valid strobe.

When stripping is enabled, characters equal to the sync character are dropped instead of delivered. The sync character is the low character-length bits of the pattern. A mode input replaces pattern hunting with an external sync strobe. A hunt command forces the block back into hunting at any time and discards any partly assembled character. A registered status output reports in-sync. A second output pulses for one cycle on every sync detection.

Top module: `rx_sync_hunter`

## Requirements
- R1: After reset, `in_sync`, `sync_seen` and `char_valid` are 0, and `char_data` is all zeros.
- R2: While hunting with `cfg_ext_mode`=0, a bit sampled with `bit_en`=1 can complete a match. A match needs at least L bits received since the last reset or hunt command. It also needs the last L bits to equal `cfg_sync_pat[L-1:0]`: the earliest of those bits is compared with pattern bit L-1 and the newest with bit 0. On a match, `in_sync` is 1 from the next clock edge and `sync_seen` is 1 for exactly that one cycle.
- R3: The effective sync length L is `cfg_sync_len` clamped to the range 2..16. Pattern bits at and above position L never affect matching.
- R4: After sync, the first character begins with the first bit sampled after the sync-entry edge. Each character's first received bit lands in `char_data[C-1]` and its last in `char_data[0]`, with the bits above C zero. `char_valid` is 1 for exactly the cycle after the edge that samples the character's last bit.
- R5: The effective character length C is `cfg_char_len` clamped to the range 1..8.
- R6: With `cfg_strip`=1, a completed character equal to `cfg_sync_pat[C-1:0]` gives no `char_valid` pulse. `char_data` keeps its previous value whenever `char_valid` is 0. With `cfg_strip`=0 such characters are delivered.
- R7: While in sync, every completed character equal to `cfg_sync_pat[C-1:0]` pulses `sync_seen` for one cycle, whether or not it is stripped.
- R8: With `cfg_ext_mode`=1, pattern matching never causes sync. While hunting, a cycle with `ext_sync`=1 sets `in_sync` from the next edge and pulses `sync_seen`, and framing starts as in R4.
- R9: `hunt_cmd`=1 in a cycle clears `in_sync` from the next edge and discards the partial character, with no `char_valid`. It takes priority over a bit sampled in the same cycle, and that bit does not count toward the L bits of R2.
- R10: In a cycle with `bit_en`=0, no bit is taken into the window or into a character, and `char_valid` stays 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `rx_bit` for this cycle |
| rx_bit | input | 1 | Recovered serial data bit |
| cfg_sync_len | input | 5 | Sync pattern length in bits (clamped 2..16) |
| cfg_sync_pat | input | 16 | Sync pattern, newest bit at position 0 |
| cfg_char_len | input | 4 | Character length in bits (clamped 1..8) |
| cfg_strip | input | 1 | Drop characters equal to the sync character |
| cfg_ext_mode | input | 1 | Use `ext_sync` instead of pattern hunting |
| ext_sync | input | 1 | External sync strobe, used in external mode |
| hunt_cmd | input | 1 | Return to hunting and discard the partial character |
| char_data | output | 8 | Last delivered character, right-aligned |
| char_valid | output | 1 | One-cycle strobe for a new character |
| in_sync | output | 1 | Character framing is active |
| sync_seen | output | 1 | One-cycle pulse on each sync detection |

## Verification
A window or fill count that is wrong shows up as `in_sync` rising one bit too early or too late. It can also show up as a false match on bits left over from before a hunt command, visible one cycle after the offending bit. A character counter off by one shifts every following `char_data` value and moves the `char_valid` pulse. This shows on the very first character after sync, within C bit times. Faults in stripping and in the external-sync path show as a missing or extra strobe or `sync_seen` pulse in the cycle right after the deciding bit or strobe.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_SYNC = 1'b1
  } rxs_state_e;
endpackage

// File: rtl/rxs_window.sv
module rxs_window #(
  parameter int SYNC_W = 16,
  parameter int SLEN_W = $clog2(SYNC_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              clear,
  input  logic [SLEN_W-1:0] len,
  input  logic [SYNC_W-1:0] pattern,
  output logic              match_now
);
  localparam logic [SLEN_W-1:0] FILL_MAX = SLEN_W'(SYNC_W);

  logic [SYNC_W-1:0] win_q;
  logic [SYNC_W-1:0] win_next;
  logic [SYNC_W-1:0] mask;
  logic [SLEN_W-1:0] fill_q;
  logic [SLEN_W-1:0] fill_next;

  for (genvar i = 0; i < SYNC_W; i++) begin : g_mask
    assign mask[i] = (SLEN_W'(i) < len);
  end

  assign win_next  = {win_q[SYNC_W-2:0], rx_bit};
  assign fill_next = (fill_q == FILL_MAX) ? fill_q : fill_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      if (bit_en) win_q <= win_next;
      if (clear) fill_q <= '0;
      else if (bit_en) fill_q <= fill_next;
    end
  end

  assign match_now = bit_en && !clear && (fill_next >= len) &&
                     ((win_next & mask) == (pattern & mask));

  AST_FILL_SAT: assert property (@(posedge clk) disable iff (rst)
    (fill_q == FILL_MAX && !clear) |=> (fill_q == FILL_MAX)); // R2
endmodule

// File: rtl/rxs_framer.sv
module rxs_framer #(
  parameter int CHAR_W = 8,
  parameter int CLEN_W = $clog2(CHAR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              flush,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic [CLEN_W-1:0] len,
  input  logic [CHAR_W-1:0] sync_char,
  input  logic              strip,
  output logic [CHAR_W-1:0] char_data,
  output logic              char_valid,
  output logic              sync_hit
);
  logic [CHAR_W-1:0] sr_q;
  logic [CHAR_W-1:0] shifted;
  logic [CHAR_W-1:0] cmask;
  logic [CHAR_W-1:0] word;
  logic [CLEN_W-1:0] cnt_q;
  logic [CLEN_W-1:0] cnt_inc;
  logic              step;
  logic              done;
  logic              is_sync;
  logic [CHAR_W-1:0] data_q;
  logic              valid_q;

  for (genvar i = 0; i < CHAR_W; i++) begin : g_cmask
    assign cmask[i] = (CLEN_W'(i) < len);
  end

  assign shifted  = {sr_q[CHAR_W-2:0], rx_bit};
  assign word     = shifted & cmask;
  assign cnt_inc  = cnt_q + 1'b1;
  assign step     = active && bit_en && !flush;
  assign done     = step && (cnt_inc >= len);
  assign is_sync  = (word == (sync_char & cmask));
  assign sync_hit = done && is_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (flush || !active) begin
        sr_q  <= '0;
        cnt_q <= '0;
      end else if (step) begin
        if (done) begin
          sr_q  <= '0;
          cnt_q <= '0;
        end else begin
          sr_q  <= shifted;
          cnt_q <= cnt_inc;
        end
      end
      valid_q <= done && !(strip && is_sync);
      if (done && !(strip && is_sync)) data_q <= word;
    end
  end

  assign char_data  = data_q;
  assign char_valid = valid_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> !char_valid); // R10
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !char_valid |-> $stable(char_data)); // R6
endmodule

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hunt_cmd,
  input  logic ext_mode,
  input  logic ext_sync,
  input  logic match_now,
  input  logic char_sync_hit,
  output logic in_sync,
  output logic sync_seen
);
  rxs_state_e state_q;
  rxs_state_e state_d;
  logic       enter;
  logic       seen_q;

  assign enter = !hunt_cmd && (state_q == ST_HUNT) &&
                 (ext_mode ? ext_sync : match_now);

  always_comb begin
    state_d = state_q;
    if (hunt_cmd) state_d = ST_HUNT;
    else if (enter) state_d = ST_SYNC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= enter || (char_sync_hit && !hunt_cmd);
    end
  end

  assign in_sync   = (state_q == ST_SYNC);
  assign sync_seen = seen_q;

  AST_EXT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ext_mode && !ext_sync && state_q == ST_HUNT) |=> (state_q == ST_HUNT)); // R8
endmodule

// File: rtl/rx_sync_hunter.sv
module rx_sync_hunter #(
  parameter int SYNC_W = 16,
  parameter int CHAR_W = 8,
  localparam int SLEN_W = $clog2(SYNC_W + 1),
  localparam int CLEN_W = $clog2(CHAR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic [SLEN_W-1:0] cfg_sync_len,
  input  logic [SYNC_W-1:0] cfg_sync_pat,
  input  logic [CLEN_W-1:0] cfg_char_len,
  input  logic              cfg_strip,
  input  logic              cfg_ext_mode,
  input  logic              ext_sync,
  input  logic              hunt_cmd,
  output logic [CHAR_W-1:0] char_data,
  output logic              char_valid,
  output logic              in_sync,
  output logic              sync_seen
);
  localparam logic [SLEN_W-1:0] SLEN_MIN = SLEN_W'(2);
  localparam logic [SLEN_W-1:0] SLEN_MAX = SLEN_W'(SYNC_W);
  localparam logic [CLEN_W-1:0] CLEN_MIN = CLEN_W'(1);
  localparam logic [CLEN_W-1:0] CLEN_MAX = CLEN_W'(CHAR_W);

  logic [SLEN_W-1:0] sync_len_eff;
  logic [CLEN_W-1:0] char_len_eff;
  logic              match_now;
  logic              char_sync_hit;

  always_comb begin
    if (cfg_sync_len < SLEN_MIN)      sync_len_eff = SLEN_MIN;
    else if (cfg_sync_len > SLEN_MAX) sync_len_eff = SLEN_MAX;
    else                              sync_len_eff = cfg_sync_len;
    if (cfg_char_len < CLEN_MIN)      char_len_eff = CLEN_MIN;
    else if (cfg_char_len > CLEN_MAX) char_len_eff = CLEN_MAX;
    else                              char_len_eff = cfg_char_len;
  end

  rxs_window #(.SYNC_W(SYNC_W), .SLEN_W(SLEN_W)) u_window (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .rx_bit    (rx_bit),
    .clear     (hunt_cmd),
    .len       (sync_len_eff),
    .pattern   (cfg_sync_pat),
    .match_now (match_now)
  );

  rxs_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .hunt_cmd      (hunt_cmd),
    .ext_mode      (cfg_ext_mode),
    .ext_sync      (ext_sync),
    .match_now     (match_now),
    .char_sync_hit (char_sync_hit),
    .in_sync       (in_sync),
    .sync_seen     (sync_seen)
  );

  rxs_framer #(.CHAR_W(CHAR_W), .CLEN_W(CLEN_W)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .active     (in_sync),
    .flush      (hunt_cmd),
    .bit_en     (bit_en),
    .rx_bit     (rx_bit),
    .len        (char_len_eff),
    .sync_char  (cfg_sync_pat[CHAR_W-1:0]),
    .strip      (cfg_strip),
    .char_data  (char_data),
    .char_valid (char_valid),
    .sync_hit   (char_sync_hit)
  );

  AST_VALID_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
    char_valid |-> $past(in_sync)); // R4
  AST_HUNT_DROPS: assert property (@(posedge clk) disable iff (rst)
    hunt_cmd |=> (!in_sync && !char_valid)); // R9
  AST_ROSE_SEEN: assert property (@(posedge clk) disable iff (rst)
    $rose(in_sync) |-> sync_seen); // R2
endmodule

// File: tb/test_rx_sync_hunter.sv
`timescale 1ns/1ps
module test_rx_sync_hunter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        rx_bit = 1'b0;
  logic [4:0]  cfg_sync_len = 5'd8;
  logic [15:0] cfg_sync_pat = 16'h0000;
  logic [3:0]  cfg_char_len = 4'd8;
  logic        cfg_strip = 1'b0;
  logic        cfg_ext_mode = 1'b0;
  logic        ext_sync = 1'b0;
  logic        hunt_cmd = 1'b0;
  logic [7:0]  char_data;
  logic        char_valid;
  logic        in_sync;
  logic        sync_seen;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  bit          m_hunt = 1;
  logic [15:0] hist = '0;
  int          hcnt = 0;
  int          ccnt = 0;
  logic [7:0]  csr = '0;
  logic [7:0]  e_data = '0;
  bit          e_valid = 0;
  bit          e_seen = 0;
  int          L = 8;
  int          C = 8;
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  rx_sync_hunter i_rx_sync_hunter (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .cfg_sync_len(cfg_sync_len), .cfg_sync_pat(cfg_sync_pat),
    .cfg_char_len(cfg_char_len), .cfg_strip(cfg_strip),
    .cfg_ext_mode(cfg_ext_mode), .ext_sync(ext_sync), .hunt_cmd(hunt_cmd),
    .char_data(char_data), .char_valid(char_valid),
    .in_sync(in_sync), .sync_seen(sync_seen)
  );

  function automatic logic [15:0] lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic step(input logic en, input logic b, input logic ex, input logic hc,
                      input string tag);
    logic [15:0] lmask;
    logic [7:0]  cmask;
    logic [7:0]  word;
    bit_en = en; rx_bit = b; ext_sync = ex; hunt_cmd = hc;
    lmask = 16'((32'd1 << L) - 1);
    cmask = 8'((32'd1 << C) - 1);
    e_seen = 0; e_valid = 0;
    if (en) hist = {hist[14:0], b};
    if (hc) begin
      m_hunt = 1; hcnt = 0; ccnt = 0; csr = '0;
    end else begin
      if (en && hcnt < 16) hcnt++;
      if (m_hunt) begin
        if (cfg_ext_mode) begin
          if (ex) begin m_hunt = 0; e_seen = 1; ccnt = 0; csr = '0; end
        end else if (en && hcnt >= L && ((hist ^ cfg_sync_pat) & lmask) == 16'd0) begin
          m_hunt = 0; e_seen = 1; ccnt = 0; csr = '0;
        end
      end else if (en) begin
        csr = {csr[6:0], b};
        ccnt++;
        if (ccnt >= C) begin
          word = csr & cmask;
          ccnt = 0; csr = '0;
          if (word == (cfg_sync_pat[7:0] & cmask)) e_seen = 1;
          if (!(cfg_strip && word == (cfg_sync_pat[7:0] & cmask))) begin
            e_valid = 1; e_data = word;
          end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, "/R2"}, "in_sync", int'(in_sync), int'(!m_hunt));
    check({tag, "/R7"}, "sync_seen", int'(sync_seen), int'(e_seen));
    check({tag, "/R6"}, "char_valid", int'(char_valid), int'(e_valid));
    check({tag, "/R4"}, "char_data", int'(char_data), int'(e_data));
  endtask

  task automatic send(input logic b, input string tag);
    step(1'b1, b, 1'b0, 1'b0, tag);
    step(1'b0, ~b, 1'b0, 1'b0, "R10");
  endtask

  task automatic setup(input int sl_raw, input int cl_raw, input bit strip, input bit ext);
    cfg_sync_len = 5'(sl_raw);
    cfg_char_len = 4'(cl_raw);
    cfg_strip = strip;
    cfg_ext_mode = ext;
    lf = lfsr(lf);
    cfg_sync_pat = lf;
    L = (sl_raw < 2) ? 2 : (sl_raw > 16) ? 16 : sl_raw;
    C = (cl_raw < 1) ? 1 : (cl_raw > 8) ? 8 : cl_raw;
    step(1'b0, 1'b0, 1'b0, 1'b1, "R9");
  endtask

  task automatic run_case(input int sl_raw, input int cl_raw, input bit strip,
                          input string tag);
    setup(sl_raw, cl_raw, strip, 1'b0);
    for (int i = 0; i < 12; i++) begin lf = lfsr(lf); send(lf[0], tag); end
    for (int i = L - 1; i >= 0; i--) send(cfg_sync_pat[i], tag);
    for (int k = 0; k < 4; k++) begin
      lf = lfsr(lf);
      for (int i = C - 1; i >= 0; i--)
        send((k == 1) ? cfg_sync_pat[i] : lf[i], tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "in_sync", int'(in_sync), 0);
    check("R1", "sync_seen", int'(sync_seen), 0);
    check("R1", "char_valid", int'(char_valid), 0);
    check("R1", "char_data", int'(char_data), 0);

    // sweep every legal sync and character length, stripping alternating
    for (int sl = 2; sl <= 16; sl++)
      for (int cl = 1; cl <= 8; cl++)
        run_case(sl, cl, ((sl + cl) % 2) == 1, "R2");

    // out-of-range lengths are clamped
    run_case(0, 0, 1'b0, "R3");
    run_case(1, 9, 1'b1, "R5");
    run_case(31, 15, 1'b0, "R3");
    run_case(17, 8, 1'b1, "R5");

    // external sync: pattern ignored, strobe starts framing
    for (int cl = 1; cl <= 8; cl++) begin
      setup(8, cl, cl[0], 1'b1);
      for (int i = 7; i >= 0; i--) send(cfg_sync_pat[i], "R8");
      for (int i = 7; i >= 0; i--) send(cfg_sync_pat[i], "R8");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R8");
      for (int k = 0; k < 3; k++) begin
        lf = lfsr(lf);
        for (int i = C - 1; i >= 0; i--)
          send((k == 0) ? cfg_sync_pat[i] : lf[i], "R8");
      end
    end

    // hunt command mid-character, with a bit in the same cycle
    for (int cl = 2; cl <= 8; cl++) begin
      run_case(6, cl, 1'b0, "R9");
      send(1'b1, "R9");
      step(1'b1, 1'b1, 1'b0, 1'b1, "R9");
      for (int i = 5; i >= 1; i--) send(cfg_sync_pat[i], "R9");
      for (int i = 5; i >= 0; i--) send(cfg_sync_pat[i], "R9");
      for (int i = C - 1; i >= 0; i--) send(lf[i], "R9");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule